// File: doc/BRIEF.md
# Ethernet Buffer Event Interrupt Controller

This block holds the interrupt enables and latched buffer events of a small Ethernet controller. Single-cycle event pulses come in from the receive and transmit datapaths. Each pulse sets a bit in an event register. A single level interrupt output is raised whenever a latched event has its enable set. Two saturating 10-bit counters track receive misses and transmit collisions. Each counter posts an overflow event when it steps from 0x1FF to 0x200.

The host uses a plain register port with a 2-bit address:

| Address | Register |
|---|---|
| 0 | configuration |
| 1 | event |
| 2 | miss counter |
| 3 | collision counter |

A read is requested with `host_rd`. Its data is returned one cycle later on `host_rdata`, qualified by `host_rvalid`. The port has no back-pressure: every request is accepted, and its response appears exactly one cycle later. Reading the event register or a counter clears it.

Top module: `bufevt_top`

## Requirements
- R1: The configuration register resets to 0x000B. Bits [5:0] always read 6'b001011 and ignore writes. Bit 14 reads 0. Bits 15 and 13..7 are writable enables:
  - bit 7: DMA frame
  - bit 8: ready-for-transmit
  - bit 9: underrun
  - bit 10: miss
  - bit 11: 128-byte
  - bit 12: miss-counter overflow
  - bit 13: collision-counter overflow
  - bit 15: destination match
- R2: A write to address 0 with data bit 6 set sets event bit 6 on the next cycle, which asserts `irq`. Configuration bit 6 always reads 0.
- R3: Event pulses set these event bits one cycle after the pulse:
  - `ev_rx_dma_done`: bit 7
  - `ev_tx_ready`: bit 8
  - `ev_tx_underrun`: bit 9
  - `ev_rx_miss`: bit 10
  - `ev_rx128`: bit 11
  - `ev_dest_match`: bit 15
- R4: `irq` is high exactly when some latched event bit has its configuration enable set, or when event bit 6 is set. An event whose enable is clear still latches but leaves `irq` low.
- R5: A read of address 1 returns the event bits and clears them. An event pulse in the same cycle as the read is absent from that read and is returned by the next read.
- R6: An `ev_tx_underrun` pulse makes `tx_abandon` high for exactly the next cycle.
- R7: An `ev_rx128` pulse clears event bit 15 and sets bit 11. If both pulses arrive in the same cycle, only bit 11 is set.
- R8: While `mode_auto_dma` or `mode_dma_only` is high, the 128-byte enable is treated as 0 for `irq`.
- R9: `ev_rx_miss` increments the miss counter. `ev_tx_collision` increments the collision counter. An increment from 0x1FF to 0x200 sets event bit 12 (miss) or bit 13 (collision).
- R10: The counters saturate at 0x3FF.
- R11: A read of a counter (addresses 2 and 3) returns its value and clears it. An increment in the same cycle leaves the counter at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low synchronous reset |
| host_wr | input | 1 | register write strobe |
| host_rd | input | 1 | register read strobe |
| host_addr | input | 2 | register address |
| host_wdata | input | 16 | write data |
| host_rdata | output | 16 | read data, one cycle after `host_rd` |
| host_rvalid | output | 1 | read data valid |
| ev_rx_dma_done | input | 1 | frame received and DMA done pulse |
| ev_tx_ready | input | 1 | ready-for-transmit pulse |
| ev_tx_underrun | input | 1 | transmit underrun pulse |
| ev_rx_miss | input | 1 | receive miss pulse |
| ev_dest_match | input | 1 | destination address match pulse |
| ev_rx128 | input | 1 | 128 bytes received pulse |
| ev_tx_collision | input | 1 | collision during transmit pulse |
| mode_auto_dma | input | 1 | automatic receive DMA mode |
| mode_dma_only | input | 1 | DMA-only receive mode |
| irq | output | 1 | interrupt request |
| tx_abandon | output | 1 | drop the current transmit frame |

## Verification
Two pairs of functions can meet in one cycle.

- **Clear-on-read against an arriving event.** An event pulse or counter increment may land in the same cycle as the read that clears the register. The bench drives the pulse and the read strobe on the same falling edge. It then expects the first read to omit the new event and the second read to return it. For a counter, the second read must return 1.
- **Replacement against a destination match.** A 128-byte pulse may coincide with a destination-match pulse. The bench expects the 128-byte bit alone to be set.

// File: rtl/bufevt_pkg.sv
package bufevt_pkg;
  localparam int DW = 16;
  localparam int CNT_W = 10;

  localparam logic [1:0] A_CFG  = 2'd0;
  localparam logic [1:0] A_EVT  = 2'd1;
  localparam logic [1:0] A_MISS = 2'd2;
  localparam logic [1:0] A_COL  = 2'd3;

  localparam int B_SW    = 6;
  localparam int B_DMA   = 7;
  localparam int B_RDY   = 8;
  localparam int B_UNDR  = 9;
  localparam int B_MISS  = 10;
  localparam int B_R128  = 11;
  localparam int B_MOVF  = 12;
  localparam int B_COVF  = 13;
  localparam int B_DEST  = 15;

  localparam logic [5:0]    CFG_ID    = 6'b001011;
  localparam logic [DW-1:0] CFG_WMASK = 16'hBF80;
endpackage

// File: rtl/bufevt_cfg.sv
module bufevt_cfg
  import bufevt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  input  logic          mask_r128,
  output logic [DW-1:0] cfg_rd,
  output logic [DW-1:0] en_eff,
  output logic          sw_req
);
  logic [DW-1:0] en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else if (wr) en_q <= wdata & CFG_WMASK;
  end

  always_comb begin
    cfg_rd = en_q;
    cfg_rd[5:0] = CFG_ID;
    en_eff = en_q;
    en_eff[B_SW] = 1'b1;
    if (mask_r128) en_eff[B_R128] = 1'b0;
  end

  assign sw_req = wr & wdata[B_SW];
endmodule

// File: rtl/bufevt_latch.sv
module bufevt_latch
  import bufevt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] set,
  input  logic          clr,
  output logic [DW-1:0] ev_q
);
  logic [DW-1:0] kept, nxt;

  always_comb begin
    kept = clr ? '0 : ev_q;
    nxt = kept | set;
    if (set[B_R128]) nxt[B_DEST] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ev_q <= '0;
    else ev_q <= nxt;
  end
endmodule

// File: rtl/bufevt_counter.sv
module bufevt_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         half_cross
);
  localparam logic [W-1:0] HALF_M1 = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= inc ? {{(W-1){1'b0}}, 1'b1} : '0;
    else if (inc && cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign half_cross = inc & ~clr & (cnt == HALF_M1);
endmodule

// File: rtl/bufevt_top.sv
module bufevt_top
  import bufevt_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [1:0]    host_addr,
  input  logic [15:0]   host_wdata,
  output logic [15:0]   host_rdata,
  output logic          host_rvalid,
  input  logic          ev_rx_dma_done,
  input  logic          ev_tx_ready,
  input  logic          ev_tx_underrun,
  input  logic          ev_rx_miss,
  input  logic          ev_dest_match,
  input  logic          ev_rx128,
  input  logic          ev_tx_collision,
  input  logic          mode_auto_dma,
  input  logic          mode_dma_only,
  output logic          irq,
  output logic          tx_abandon
);
  logic [DW-1:0] cfg_rd, en_eff, ev_q, ev_set;
  logic          sw_req, miss_cross, col_cross;
  logic [CNT_W-1:0] miss_cnt, col_cnt;

  wire cfg_wr  = host_wr & (host_addr == A_CFG);
  wire evt_rd  = host_rd & (host_addr == A_EVT);
  wire miss_rd = host_rd & (host_addr == A_MISS);
  wire col_rd  = host_rd & (host_addr == A_COL);

  bufevt_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .wdata(host_wdata),
    .mask_r128(mode_auto_dma | mode_dma_only),
    .cfg_rd(cfg_rd), .en_eff(en_eff), .sw_req(sw_req)
  );

  bufevt_counter #(.W(CNT_W)) u_miss (
    .clk(clk), .rst_n(rst_n), .inc(ev_rx_miss), .clr(miss_rd),
    .cnt(miss_cnt), .half_cross(miss_cross)
  );

  bufevt_counter #(.W(CNT_W)) u_col (
    .clk(clk), .rst_n(rst_n), .inc(ev_tx_collision), .clr(col_rd),
    .cnt(col_cnt), .half_cross(col_cross)
  );

  always_comb begin
    ev_set = '0;
    ev_set[B_SW]   = sw_req;
    ev_set[B_DMA]  = ev_rx_dma_done;
    ev_set[B_RDY]  = ev_tx_ready;
    ev_set[B_UNDR] = ev_tx_underrun;
    ev_set[B_MISS] = ev_rx_miss;
    ev_set[B_R128] = ev_rx128;
    ev_set[B_MOVF] = miss_cross;
    ev_set[B_COVF] = col_cross;
    ev_set[B_DEST] = ev_dest_match;
  end

  bufevt_latch u_evt (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(evt_rd), .ev_q(ev_q)
  );

  assign irq = |(ev_q & en_eff);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
      tx_abandon  <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      tx_abandon  <= ev_tx_underrun;
      if (host_rd) begin
        case (host_addr)
          A_CFG:   host_rdata <= cfg_rd;
          A_EVT:   host_rdata <= ev_q;
          A_MISS:  host_rdata <= {{(DW-CNT_W){1'b0}}, miss_cnt};
          default: host_rdata <= {{(DW-CNT_W){1'b0}}, col_cnt};
        endcase
      end
    end
  end
endmodule

// File: rtl/bufevt_chk.sv
module bufevt_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        host_wr,
  input logic        host_rd,
  input logic [1:0]  host_addr,
  input logic [15:0] host_wdata,
  input logic [15:0] host_rdata,
  input logic        host_rvalid,
  input logic        ev_tx_underrun,
  input logic        ev_rx128,
  input logic        ev_rx_miss,
  input logic [15:0] ev_q,
  input logic [9:0]  miss_cnt,
  input logic        tx_abandon,
  input logic        irq
);
  a_r1_id_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == 2'd0) |=> (host_rvalid && host_rdata[5:0] == 6'b001011));

  a_r2_sw_event: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == 2'd0 && host_wdata[6]) |=> (ev_q[6] && irq));

  a_r6_abandon: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_underrun |=> tx_abandon);

  a_r7_replace: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx128 |=> (ev_q[11] && !ev_q[15]));

  a_r9_cross: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_miss && miss_cnt == 10'h1FF && !(host_rd && host_addr == 2'd2)) |=> ev_q[12]);

  a_r10_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_cnt == 10'h3FF && !(host_rd && host_addr == 2'd2)) |=> miss_cnt == 10'h3FF);
endmodule

bind bufevt_top bufevt_chk u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .host_rvalid(host_rvalid), .ev_tx_underrun(ev_tx_underrun),
  .ev_rx128(ev_rx128), .ev_rx_miss(ev_rx_miss), .ev_q(ev_q),
  .miss_cnt(miss_cnt), .tx_abandon(tx_abandon), .irq(irq)
);

// File: tb/test_bufevt_top.sv
module test_bufevt_top;
  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [1:0] host_addr = 0;
  logic [15:0] host_wdata = 0, host_rdata;
  logic host_rvalid, irq, tx_abandon;
  logic ev_rx_dma_done = 0, ev_tx_ready = 0, ev_tx_underrun = 0, ev_rx_miss = 0;
  logic ev_dest_match = 0, ev_rx128 = 0, ev_tx_collision = 0;
  logic mode_auto_dma = 0, mode_dma_only = 0;

  int checks = 0, fails = 0;
  logic [15:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  bufevt_top i_bufevt_top (.*);

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rst_n && host_rvalid) begin
      if (exp_q.size() == 0) check("unexpected read", 16'h1, 16'h0);
      else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    host_wr = 1; host_addr = a; host_wdata = d; tick(); host_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, logic [15:0] e, string tag);
    exp_q.push_back(e); tag_q.push_back(tag);
    host_rd = 1; host_addr = a; tick(); host_rd = 0; tick();
  endtask

  task automatic pulse_miss(int n);
    for (int i = 0; i < n; i++) begin ev_rx_miss = 1; tick(); end
    ev_rx_miss = 0;
  endtask

  task automatic pulse_col(int n);
    for (int i = 0; i < n; i++) begin ev_tx_collision = 1; tick(); end
    ev_tx_collision = 0;
  endtask

  initial begin
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(); tick(); rst_n = 1; tick();
    check("R4 reset irq", {15'd0, irq}, 16'h0);
    rd(2'd0, 16'h000B, "R1 reset cfg");
    rd(2'd1, 16'h0000, "R5 reset events");

    wr(2'd0, 16'hFFFF);
    rd(2'd0, 16'hBF8B, "R1 writable mask");

    // R2 software interrupt with all enables off
    wr(2'd0, 16'h0040);
    check("R2 sw irq", {15'd0, irq}, 16'h1);
    rd(2'd0, 16'h000B, "R2 cmd self clears");
    rd(2'd1, 16'h0040, "R2 sw event");
    check("R5 irq after clear", {15'd0, irq}, 16'h0);

    // R4/R6 underrun latched without enable
    ev_tx_underrun = 1; tick(); ev_tx_underrun = 0;
    check("R6 abandon", {15'd0, tx_abandon}, 16'h1);
    check("R4 masked irq", {15'd0, irq}, 16'h0);
    tick();
    check("R6 abandon one cycle", {15'd0, tx_abandon}, 16'h0);
    wr(2'd0, 16'h0200);
    check("R4 enabled irq", {15'd0, irq}, 16'h1);
    rd(2'd1, 16'h0200, "R3 underrun bit");

    // R3 remaining pulses
    ev_rx_dma_done = 1; ev_tx_ready = 1; tick(); ev_rx_dma_done = 0; ev_tx_ready = 0;
    rd(2'd1, 16'h0180, "R3 dma and ready bits");

    // R7 replacement
    ev_dest_match = 1; tick(); ev_dest_match = 0;
    rd(2'd1, 16'h8000, "R7 dest first");
    ev_dest_match = 1; tick(); ev_dest_match = 0;
    ev_rx128 = 1; tick(); ev_rx128 = 0;
    rd(2'd1, 16'h0800, "R7 replaced by rx128");
    ev_dest_match = 1; ev_rx128 = 1; tick(); ev_dest_match = 0; ev_rx128 = 0;
    rd(2'd1, 16'h0800, "R7 same cycle");

    // R8 DMA modes mask 128-byte enable
    wr(2'd0, 16'h0800);
    mode_auto_dma = 1;
    ev_rx128 = 1; tick(); ev_rx128 = 0;
    check("R8 auto dma masks", {15'd0, irq}, 16'h0);
    mode_auto_dma = 0; mode_dma_only = 1; tick();
    check("R8 dma only masks", {15'd0, irq}, 16'h0);
    mode_dma_only = 0; tick();
    check("R8 unmasked", {15'd0, irq}, 16'h1);
    rd(2'd1, 16'h0800, "R8 event kept");

    // R5 same-cycle event and read
    ev_rx_dma_done = 1; exp_q.push_back(16'h0000); tag_q.push_back("R5 same cycle read");
    host_rd = 1; host_addr = 2'd1; tick(); host_rd = 0; ev_rx_dma_done = 0; tick();
    rd(2'd1, 16'h0080, "R5 kept for next read");

    // R9 miss counter crossing
    wr(2'd0, 16'h1000);
    pulse_miss(511);
    rd(2'd1, 16'h0400, "R9 no cross before 0x200");
    check("R9 no irq yet", {15'd0, irq}, 16'h0);
    pulse_miss(1);
    check("R9 cross irq", {15'd0, irq}, 16'h1);
    rd(2'd1, 16'h1400, "R9 miss overflow event");
    rd(2'd2, 16'h0200, "R11 miss count");
    rd(2'd2, 16'h0000, "R11 cleared");

    // R10 saturation on collision counter
    pulse_col(1100);
    rd(2'd3, 16'h03FF, "R10 saturated");
    rd(2'd1, 16'h2000, "R9 collision overflow event");

    // R11 increment same cycle as read
    pulse_col(5);
    ev_tx_collision = 1; exp_q.push_back(16'h0005); tag_q.push_back("R11 read value");
    host_rd = 1; host_addr = 2'd3; tick(); host_rd = 0; ev_tx_collision = 0; tick();
    rd(2'd3, 16'h0001, "R11 same cycle increment");

    tick(); tick();
    if (exp_q.size() != 0) check("reads outstanding", 16'(exp_q.size()), 16'h0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule